// File: doc/BRIEF.md
# Single-Command SPI Flash Engine

This block is a byte-wide, register-mapped SPI master that carries out one serial-flash command at a time. Software loads an opcode into a dedicated register, packs the number of bytes to send and to receive into a count register, and pushes the outgoing payload into an eight-entry ring buffer. It then sets a start bit. The engine drives chip select low and shifts out the opcode followed by the payload, then clocks in the requested response bytes. The start bit reads back as a busy flag until the transfer ends.

The ring buffer serves both directions. Every byte exchanged after the opcode overwrites the entry it was taken from with whatever the flash returned at the same time. Response bytes land in the entries right after the payload. The buffer pointer is visible to software and can be reset by it. After a command, software resets the pointer, reads past the payload entries and collects the response. Three serial clock rates can be selected through a configuration field.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x0 holds the opcode byte and reads back as written. Each command shifts the opcode out first, MSB first. The opcode never occupies a ring-buffer entry.
- R2: Offset 0x1 holds the counts: receive count in bits 7:4 and transmit payload count in bits 3:0. It reads back as written. A count field above 8 behaves as 8.
- R3: Writing a 1 to bit 0 of offset 0x2 while idle starts a command. Bit 0 of offset 0x2 reads 1 from the start until the last bit is done and then returns to 0. Chip select is low exactly while it reads 1.
- R4: Writing a 1 to bit 4 of offset 0x2 while idle returns the ring pointer to 0.
- R5: Each read or write at offset 0xC while idle accesses the entry at the ring pointer and then advances the pointer by one, modulo 8.
- R6: At offset 0xD, bits 2:0 read the ring pointer and bits 5:4 hold the rate code, which resets to 1. The serial clock half-period is HALF_FAST system cycles for code 1, HALF_MID for code 2, and HALF_SLOW for codes 3 and 0. With the defaults, the full periods are 4, 6 and 8 cycles.
- R7: Payload bytes are sent from consecutive entries starting at the pointer. During the receive phase MOSI carries 0xFF. Each byte received after the opcode overwrites the entry of the same position in the sequence. Entries beyond the sequence keep their contents.
- R8: When a command ends, the ring pointer equals (start pointer + transmit count + receive count) mod 8.
- R9: SPI mode 0 is used. SCLK idles low, MISO is sampled on the rising edge, and MOSI changes only while SCLK is low.
- R10: A command produces exactly 8*(1 + transmit count + receive count) rising SCLK edges. This holds for an opcode with no payload, which still captures every requested response byte.
- R11: While busy, bus writes to any register and bus accesses at offset 0xC have no effect on the registers, the ring or the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The bench aims first at the boundaries of the byte sequence. It runs an opcode with no payload, which a design that finishes one byte early would cut short, losing the last response byte. It runs full eight-plus-eight commands that wrap the ring twice, where a wrong write index would overwrite payload before it is sent. It runs count fields above 8, which a design without clamping would turn into extra clock bursts. It also checks that the end pointer, the 0xFF fill and the untouched entries match an independent model of the ring. It pokes every register while a command is in flight, which a design that does not lock the registers would let corrupt the opcode, the rate or the pointer. It measures the clock period for every rate code, including the reserved one.

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
  parameter int HALF_FAST = 2,
  parameter int HALF_MID  = 3,
  parameter int HALF_SLOW = 4,
  parameter int MAX_BYTES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso,
  output logic       spi_cs_n
);
  localparam int TW = $clog2(HALF_SLOW + 1);
  localparam logic [3:0] CMAX = 4'(MAX_BYTES);

  logic [7:0] opcode_q, cnt_q, sh, rx;
  logic [1:0] rate_q;
  logic [2:0] ptr, bitn, np;
  logic [7:0] mem [8];
  logic       busy, sclk_q, cs_n_q, op_phase;
  logic [3:0] wr_left, rd_left, wr_eff, rd_eff;
  logic [TW-1:0] tmr, half_m1;

  assign wr_eff = (cnt_q[3:0] > CMAX) ? CMAX : cnt_q[3:0];
  assign rd_eff = (cnt_q[7:4] > CMAX) ? CMAX : cnt_q[7:4];

  always_comb begin
    case (rate_q)
      2'd1:    half_m1 = TW'(HALF_FAST - 1);
      2'd2:    half_m1 = TW'(HALF_MID - 1);
      default: half_m1 = TW'(HALF_SLOW - 1);
    endcase
  end

  wire host_wr  = bus_wr && !busy;
  wire a_op     = bus_addr == 4'h0;
  wire a_cnt    = bus_addr == 4'h1;
  wire a_ctl    = bus_addr == 4'h2;
  wire a_fifo   = bus_addr == 4'hC;
  wire a_cfg    = bus_addr == 4'hD;
  wire start    = host_wr && a_ctl && bus_wdata[0];
  wire ptr_clr  = host_wr && a_ctl && bus_wdata[4];
  wire fifo_acc = !busy && a_fifo && (bus_wr || bus_rd);
  wire tick     = busy && (tmr == half_m1);
  wire rise     = tick && !sclk_q;
  wire fall     = tick && sclk_q;
  wire byte_end = fall && (bitn == 3'd0);

  assign np = op_phase ? ptr : ptr + 3'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q <= '0; cnt_q <= '0; rate_q <= 2'd1; ptr <= '0;
      busy <= 1'b0; sclk_q <= 1'b0; cs_n_q <= 1'b1; op_phase <= 1'b0;
      sh <= '0; rx <= '0; bitn <= '0; wr_left <= '0; rd_left <= '0; tmr <= '0;
      for (int i = 0; i < 8; i++) mem[i] <= '0;
    end else begin
      if (host_wr && a_op)  opcode_q <= bus_wdata;
      if (host_wr && a_cnt) cnt_q    <= bus_wdata;
      if (host_wr && a_cfg) rate_q   <= bus_wdata[5:4];
      if (fifo_acc && bus_wr) mem[ptr] <= bus_wdata;

      if (ptr_clr)       ptr <= '0;
      else if (fifo_acc) ptr <= ptr + 3'd1;
      else if (byte_end) ptr <= np;

      if (start) begin
        busy <= 1'b1; cs_n_q <= 1'b0; sclk_q <= 1'b0; tmr <= '0;
        sh <= opcode_q; bitn <= 3'd7; op_phase <= 1'b1;
        wr_left <= wr_eff; rd_left <= rd_eff;
      end else if (busy) begin
        tmr <= tick ? '0 : tmr + 1'b1;
        if (tick) sclk_q <= ~sclk_q;
        if (rise) rx <= {rx[6:0], spi_miso};
        if (fall) begin
          if (bitn != 3'd0) begin
            sh   <= {sh[6:0], 1'b0};
            bitn <= bitn - 3'd1;
          end else begin
            if (!op_phase) mem[ptr] <= rx;
            op_phase <= 1'b0;
            bitn     <= 3'd7;
            if (wr_left != 4'd0) begin
              sh <= mem[np]; wr_left <= wr_left - 4'd1;
            end else if (rd_left != 4'd0) begin
              sh <= 8'hFF; rd_left <= rd_left - 4'd1;
            end else begin
              busy <= 1'b0; cs_n_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign spi_sclk = sclk_q;
  assign spi_cs_n = cs_n_q;
  assign spi_mosi = cs_n_q ? 1'b0 : sh[7];

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = opcode_q;
      4'h1:    bus_rdata = cnt_q;
      4'h2:    bus_rdata = {7'd0, busy};
      4'hC:    bus_rdata = mem[ptr];
      4'hD:    bus_rdata = {2'd0, rate_q, 1'b0, ptr};
      default: bus_rdata = 8'h00;
    endcase
  end

  assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (spi_cs_n && !spi_sclk));
  assert_cs_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr == $past(ptr)) || (ptr == $past(ptr) + 3'd1) || (ptr == 3'd0));
  assert_clamp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_left <= CMAX) && (rd_left <= CMAX));
  assert_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(opcode_q) && $stable(cnt_q) && $stable(rate_q)));
  assert_mosi_low_clk_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$stable(spi_mosi)) |-> !spi_sclk);
endmodule

// File: tb/spi_cmd_engine_tb_top.sv
`timescale 1ns/1ps
module spi_cmd_engine_tb_top;
  logic clk = 0, rst_n = 0;
  logic [3:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic spi_sclk, spi_mosi, spi_miso, spi_cs_n;

  spi_cmd_engine dut_i (.clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
    .bus_rdata, .spi_sclk, .spi_mosi, .spi_miso, .spi_cs_n);

  always #5 clk = ~clk;

  int total = 0, fails = 0, edge_cnt = 0, tr_id = 0, mode_err = 0;
  time t0, t1;
  logic [7:0] mosi_log [32];
  logic [7:0] model_mem [8];
  logic prev_mosi = 0;
  bit finished = 0;

  function automatic logic [7:0] resp_of(int t, int k);
    return 8'(t * 29 + k * 71 + 19);
  endfunction

  logic [7:0] cur_resp;
  assign cur_resp = resp_of(tr_id, edge_cnt / 8);
  assign spi_miso = spi_cs_n ? 1'b1 : cur_resp[7 - (edge_cnt % 8)];

  always @(posedge spi_sclk) begin
    if (spi_cs_n) mode_err++;
    else begin
      if (edge_cnt == 0) t0 = $time;
      if (edge_cnt == 1) t1 = $time;
      if (edge_cnt / 8 < 32) mosi_log[edge_cnt / 8] = {mosi_log[edge_cnt / 8][6:0], spi_mosi};
      edge_cnt++;
    end
  end

  always @(negedge clk) begin
    if (!spi_cs_n && spi_mosi != prev_mosi && spi_sclk) mode_err++;
    prev_mosi = spi_mosi;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  int cur_half = 2;

  task automatic run_cmd(input int wc_raw, input int rc_raw, input logic [7:0] op,
                         input int t, input bit meddle);
    int wc, rc;
    logic [7:0] d, txb [8];
    wc = wc_raw > 8 ? 8 : wc_raw;
    rc = rc_raw > 8 ? 8 : rc_raw;
    bus_write(4'h0, op);
    bus_write(4'h1, {4'(rc_raw), 4'(wc_raw)});
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < wc; i++) begin
      txb[i] = 8'(op + i * 13 + t);
      bus_write(4'hC, txb[i]);
      model_mem[i] = txb[i];
    end
    tr_id = t; edge_cnt = 0;
    bus_write(4'h2, 8'h11);
    if (meddle) begin
      bus_write(4'h0, 8'hEE);
      bus_write(4'h1, 8'h00);
      bus_write(4'hD, 8'h00);
      bus_write(4'hC, 8'h77);
      bus_write(4'h2, 8'h10);
    end
    for (int n = 0; n < 20000; n++) begin
      bus_read(4'h2, d);
      if (d[0] == 1'b0) break;
    end
    chk(d[0] == 1'b0 && spi_cs_n, "R3 busy cleared and cs high", d, 0);
    for (int j = 0; j < wc + rc; j++) model_mem[j % 8] = resp_of(t, j + 1);
    chk(edge_cnt == 8 * (1 + wc + rc), "R10 sclk rising edges", edge_cnt, 8 * (1 + wc + rc));
    chk(mosi_log[0] == op, "R1 opcode first on mosi", mosi_log[0], op);
    for (int i = 0; i < wc; i++)
      chk(mosi_log[1 + i] == txb[i], "R7 payload byte on mosi", mosi_log[1 + i], txb[i]);
    for (int i = 0; i < rc; i++)
      chk(mosi_log[1 + wc + i] == 8'hFF, "R7 fill byte on mosi", mosi_log[1 + wc + i], 8'hFF);
    chk(t1 - t0 == time'(20 * cur_half), "R6 sclk period ns", int'(t1 - t0), 20 * cur_half);
    bus_read(4'hD, d);
    chk(d[2:0] == 3'((wc + rc) % 8), "R8 end pointer", d[2:0], (wc + rc) % 8);
    bus_read(4'h0, d);
    chk(d == op, "R11 opcode kept", d, op);
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 8; i++) begin
      bus_read(4'hC, d);
      chk(d == model_mem[i], "R7 ring entry", d, model_mem[i]);
    end
  endtask

  localparam logic [15:0] VEC [6] = '{
    {4'd0, 4'd3, 8'h9F}, {4'd3, 4'd5, 8'h03}, {4'd1, 4'd0, 8'h06},
    {4'd8, 4'd8, 8'h02}, {4'd0, 4'd0, 8'h05}, {4'd4, 4'd2, 8'h0B}};

  initial begin
    logic [7:0] d;
    for (int i = 0; i < 8; i++) model_mem[i] = 8'h00;
    for (int i = 0; i < 32; i++) mosi_log[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk(spi_cs_n && !spi_sclk, "R3 idle pins after reset", {spi_cs_n, spi_sclk}, 2'b10);
    bus_read(4'h2, d); chk(d == 8'h00, "R3 idle control after reset", d, 0);
    bus_read(4'hD, d); chk(d == 8'h10, "R6 config reset value", d, 8'h10);
    bus_read(4'h0, d); chk(d == 8'h00, "R1 opcode reset value", d, 0);

    for (int v = 0; v < 6; v++)
      run_cmd(VEC[v][15:12], VEC[v][11:8], VEC[v][7:0], v + 1, 0);

    // R2: oversize counts act as eight
    bus_write(4'h1, 8'h9A);
    bus_read(4'h1, d); chk(d == 8'h9A, "R2 count readback", d, 8'h9A);
    run_cmd(10, 9, 8'h3B, 11, 0);

    // R5: wrap of the ring pointer
    bus_write(4'h2, 8'h10);
    for (int i = 0; i < 9; i++) bus_write(4'hC, 8'(8'hC0 + i));
    bus_read(4'hD, d); chk(d[2:0] == 3'd1, "R5 pointer wraps", d[2:0], 1);
    bus_write(4'h2, 8'h10);
    bus_read(4'hD, d); chk(d[2:0] == 3'd0, "R4 pointer reset", d[2:0], 0);
    bus_read(4'hC, d); chk(d == 8'hC8, "R5 entry 0 overwritten on wrap", d, 8'hC8);
    bus_read(4'hC, d); chk(d == 8'hC1, "R5 entry 1 kept", d, 8'hC1);
    for (int i = 0; i < 8; i++) model_mem[i] = 8'(8'hC0 + i);
    model_mem[0] = 8'hC8;

    // R6: each rate code, reserved one behaves as slowest
    bus_write(4'hD, 8'h20); cur_half = 3; run_cmd(1, 1, 8'hA1, 12, 0);
    bus_write(4'hD, 8'h30); cur_half = 4; run_cmd(1, 1, 8'hA2, 13, 0);
    bus_write(4'hD, 8'h00); cur_half = 4; run_cmd(1, 1, 8'hA3, 14, 0);

    // R11: writes while busy are dropped
    run_cmd(2, 5, 8'h4C, 15, 1);
    bus_read(4'hD, d); chk(d[5:4] == 2'd0, "R11 rate kept while busy", d[5:4], 0);
    bus_read(4'h1, d); chk(d == 8'h52, "R11 counts kept while busy", d, 8'h52);

    chk(mode_err == 0, "R9 mode 0 timing", mode_err, 0);
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #3_000_000;
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule